// File: doc/BRIEF.md
# Dual-Width Parallel Display Bus Port

This block is the display-controller end of a parallel microcontroller bus. The bus has one enable strobe, a register-select line, a read/write line and eight data lines. The strobe is asynchronous to the controller, so the port samples the control and data lines through a short synchronizer. It acts when it sees enable fall, and it uses the values the lines held while enable was still high. The register-select line travels with each written byte as a tag. The instruction decoder uses that tag to tell commands from display data.

The bus runs either a full byte per enable cycle or, after a mode instruction, two half-byte cycles on the upper four lines. In the narrow mode the high half comes first and the low half second. Reads follow the same order, including status reads, which put the busy flag in the top bit. A shared phase pointer tracks which half comes next. The pointer returns to the high half whenever the mode actually changes, so that a new mode always starts on a byte boundary.

Completed write bytes leave on a valid/ready stream. The bus has no way to stall, so back-pressure cannot reach the microcontroller. The microcontroller must respect the busy flag instead. While `wr_ready` is low, a pending byte stays valid and unchanged. If another byte completes before acceptance, it replaces the pending one. A byte is accepted on any clock edge where `wr_valid` and `wr_ready` are both high.

Top module: `pbus_port`

## Requirements
- R1: In byte mode (`mode_nib`=0), each falling enable with `bus_rw`=0 produces exactly one byte on the stream. The byte equals lines 7..0 as held while enable was high, and `wr_rs` equals the register-select level at that time.
- R2: In half-byte mode (`mode_nib`=1), a write byte takes two enable cycles. Lines 7..4 of the first cycle form byte bits 7..4, and lines 7..4 of the second form bits 3..0. Lines 3..0 are ignored. Nothing is emitted after the first cycle. The tag is the register-select level of the second cycle.
- R3: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_rs` hold. A newer completed byte replaces the pending one. `wr_valid` falls after acceptance when no new byte arrives.
- R4: In byte mode, while enable is high with `bus_rw`=1, `bus_doe` is 1. `bus_dout` is then `rd_data` when register select is 1, or {`busy`, `rd_data[6:0]`} when it is 0.
- R5: In half-byte mode, a read byte takes two enable cycles. Lines 7..4 carry bits 7..4 first and bits 3..0 second, and lines 3..0 read as all ones.
- R6: In half-byte mode, both halves of a read come from one snapshot of the source, taken as the first cycle starts. Changes to `rd_data` or `busy` between the halves are not seen.
- R7: When `mode_ld` loads a mode that differs from the current one, the phase returns to the high half. An unfinished half-byte write is discarded.
- R8: After reset the mode is byte mode, the phase is high-half, `wr_valid` is 0 and `bus_doe` is 0.
- R9: Loading the same mode again leaves the phase untouched, so a half-byte write split around such a load still completes.
- R10: `bus_doe` stays 0 during write cycles and while enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| mode_ld | input | 1 | One-cycle strobe that loads `mode_nib` |
| mode_nib | input | 1 | Mode value: 1 = half-byte, 0 = byte |
| bus_e | input | 1 | Bus enable strobe (asynchronous) |
| bus_rs | input | 1 | Register select |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Data lines, inbound |
| bus_dout | output | 8 | Data lines, outbound |
| bus_doe | output | 1 | Output enable for the data lines |
| busy | input | 1 | Controller busy flag |
| rd_data | input | 8 | Data byte (select 1) or address/status bits (select 0) |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Consumer accepts the byte |
| wr_data | output | 8 | Assembled write byte |
| wr_rs | output | 1 | Register-select tag of the byte |

## Verification
The hardest state to reach is a half-byte write interrupted halfway by a mode load. The half already stored must be discarded when the mode really changes, and kept when the same mode is reloaded. The stimulus sends one half, toggles the mode away and back (or reloads the same mode), and then sends further halves. The count of emitted bytes shows whether the phase pointer was rewound. A second hard case is a status read whose source changes between its two halves. The bench changes `busy` and `rd_data` between the cycles and expects the earlier snapshot.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} phase_e;

  typedef struct packed {
    logic              rw;
    logic              rs;
    logic [BYTE_W-1:0] d;
  } bus_smp_t;
endpackage

// File: rtl/pbus_sampler.sv
module pbus_sampler
  import pbus_pkg::*;
#(
  parameter int unsigned SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_e,
  input  logic              bus_rw,
  input  logic              bus_rs,
  input  logic [BYTE_W-1:0] bus_din,
  output logic              e_hi,
  output logic              e_rise,
  output logic              e_fall,
  output bus_smp_t          cur,
  output bus_smp_t          held
);
  localparam int unsigned DEPTH = SYNC + 1;

  logic [DEPTH-1:0] e_pipe;
  bus_smp_t         s_pipe [DEPTH];

  // Lines travel beside enable so a falling edge pairs with data seen while high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pipe <= '0;
      for (int i = 0; i < DEPTH; i++) s_pipe[i] <= '0;
    end else begin
      e_pipe    <= {e_pipe[DEPTH-2:0], bus_e};
      s_pipe[0] <= '{rw: bus_rw, rs: bus_rs, d: bus_din};
      for (int i = 1; i < DEPTH; i++) s_pipe[i] <= s_pipe[i-1];
    end
  end

  assign e_hi   = e_pipe[SYNC-1];
  assign e_rise = e_pipe[SYNC-1] & ~e_pipe[SYNC];
  assign e_fall = ~e_pipe[SYNC-1] & e_pipe[SYNC];
  assign cur    = s_pipe[SYNC-1];
  assign held   = s_pipe[SYNC];
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic              mode_nib,
  input  logic              e_fall,
  input  bus_smp_t          held,
  output logic              mode4,
  output phase_e            phase,
  output logic              emit,
  output logic [BYTE_W-1:0] emit_data,
  output logic              emit_rs
);
  logic             mode_q;
  phase_e           phase_q;
  logic [NIB_W-1:0] hi_q;
  logic             mode_chg, step;

  assign mode_chg  = mode_ld && (mode_nib != mode_q);
  assign step      = e_fall && !mode_chg;
  assign emit      = step && !held.rw && (!mode_q || phase_q == PH_LO);
  assign emit_data = mode_q ? {hi_q, held.d[BYTE_W-1 -: NIB_W]} : held.d;
  assign emit_rs   = held.rs;
  assign mode4     = mode_q;
  assign phase     = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      phase_q <= PH_HI;
      hi_q    <= '0;
    end else begin
      if (mode_ld) mode_q <= mode_nib;
      if (mode_chg || !mode_q)
        phase_q <= PH_HI;
      else if (step)
        phase_q <= (phase_q == PH_HI) ? PH_LO : PH_HI;
      if (step && mode_q && phase_q == PH_HI && !held.rw)
        hi_q <= held.d[BYTE_W-1 -: NIB_W];
    end
  end

  // R7
  phase_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (phase_q == PH_HI));

  // R2
  nib_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q && phase_q == PH_HI) |=> (phase_q == PH_LO));
endmodule

// File: rtl/pbus_rdmux.sv
module pbus_rdmux
  import pbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_hi,
  input  logic              e_rise,
  input  bus_smp_t          cur,
  input  logic              mode4,
  input  phase_e            phase,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_doe
);
  logic [BYTE_W-1:0] snap_q, src;
  logic              oe_q;

  assign src = cur.rs ? rd_data : {busy, rd_data[BYTE_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= e_hi && cur.rw;
      if (e_rise && (!mode4 || phase == PH_HI)) snap_q <= src;
    end
  end

  always_comb begin
    if (!mode4)
      bus_dout = snap_q;
    else if (phase == PH_HI)
      bus_dout = {snap_q[BYTE_W-1 -: NIB_W], {NIB_W{1'b1}}};
    else
      bus_dout = {snap_q[NIB_W-1:0], {NIB_W{1'b1}}};
  end
  assign bus_doe = oe_q;

  // R5
  low_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && mode4) |-> (bus_dout[NIB_W-1:0] == {NIB_W{1'b1}}));
endmodule

// File: rtl/pbus_port.sv
module pbus_port
  import pbus_pkg::*;
#(
  parameter int unsigned SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic              mode_nib,
  input  logic              bus_e,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_rs
);
  logic              e_hi, e_rise, e_fall, mode4, emit, emit_rs;
  bus_smp_t          cur, held;
  phase_e            phase;
  logic [BYTE_W-1:0] emit_data;

  pbus_sampler #(.SYNC(SYNC)) u_smp (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rw(bus_rw), .bus_rs(bus_rs),
    .bus_din(bus_din), .e_hi(e_hi), .e_rise(e_rise), .e_fall(e_fall),
    .cur(cur), .held(held)
  );

  pbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_nib(mode_nib),
    .e_fall(e_fall), .held(held), .mode4(mode4), .phase(phase),
    .emit(emit), .emit_data(emit_data), .emit_rs(emit_rs)
  );

  pbus_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .e_hi(e_hi), .e_rise(e_rise), .cur(cur),
    .mode4(mode4), .phase(phase), .busy(busy), .rd_data(rd_data),
    .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_rs    <= 1'b0;
    end else if (emit) begin
      wr_valid <= 1'b1;
      wr_data  <= emit_data;
      wr_rs    <= emit_rs;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R3
  hold_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !emit) |=> (wr_valid && $stable(wr_data) && $stable(wr_rs)));

  // R1
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(e_fall));
endmodule

// File: tb/pbus_port_test.sv
module pbus_port_test;
  logic       clk = 0, rst_n = 0;
  logic       mode_ld = 0, mode_nib = 0;
  logic       bus_e = 0, bus_rs = 0, bus_rw = 0, busy = 0, wr_ready = 1;
  logic [7:0] bus_din = 0, rd_data = 0;
  logic [7:0] bus_dout, wr_data;
  logic       bus_doe, wr_valid, wr_rs;

  int checks = 0, fails = 0, got_n = 0;
  logic [7:0] got_d;
  logic       got_rs;
  bit         done = 0;

  always #4 clk = ~clk;

  pbus_port uut (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_nib(mode_nib),
    .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .busy(busy), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_rs(wr_rs)
  );

  always @(negedge clk) if (rst_n && wr_valid && wr_ready) begin
    got_n++; got_d = wr_data; got_rs = wr_rs;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ready(input logic r);
    @(posedge clk); #2 wr_ready = r;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); mode_ld = 1; mode_nib = m;
    cyc(1); mode_ld = 0; cyc(1);
  endtask

  task automatic bus_cycle(input logic rw, input logic rs, input logic [7:0] d,
                           output logic [7:0] seen, output logic oe_seen);
    @(negedge clk); bus_rw = rw; bus_rs = rs; bus_din = d;
    cyc(1); bus_e = 1; cyc(5);
    seen = bus_dout; oe_seen = bus_doe;
    bus_e = 0; cyc(6);
  endtask

  task automatic wr8(input logic rs, input logic [7:0] d);
    logic [7:0] s; logic o; int n0;
    n0 = got_n;
    bus_cycle(0, rs, d, s, o);
    chk(got_n == n0 + 1 && got_d == d && got_rs == rs, "R1", {got_rs, got_d}, {rs, d});
    chk(o == 0, "R10", o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2, exp_b; logic o, o2; int n0;
    cyc(5);
    chk(wr_valid == 0 && bus_doe == 0, "R8", {wr_valid, bus_doe}, 0);
    rst_n = 1; cyc(2);

    // R8 default byte mode, then R1 sweep
    for (int rs = 0; rs < 2; rs++)
      for (int v = 0; v < 256; v++) wr8(rs[0], v[7:0]);
    chk(bus_doe == 0, "R10", bus_doe, 0);

    // R4 byte-mode reads
    for (int rs = 0; rs < 2; rs++)
      for (int v = 0; v < 256; v++) begin
        rd_data = v[7:0]; busy = v[3];
        exp_b = rs ? v[7:0] : {v[3], v[6:0]};
        bus_cycle(1, rs[0], 8'h00, s, o);
        chk(o == 1 && s == exp_b, "R4", {o, s}, {1'b1, exp_b});
      end

    // R2 half-byte writes
    set_mode(1);
    for (int v = 0; v < 256; v++) begin
      n0 = got_n;
      bus_cycle(0, 0, {v[7:4], 4'h0}, s, o);
      chk(got_n == n0, "R2", got_n, n0);
      bus_cycle(0, 1, {v[3:0], 4'hA}, s, o);
      chk(got_n == n0 + 1 && got_d == v[7:0] && got_rs == 1, "R2", {got_rs, got_d}, {1'b1, v[7:0]});
    end

    // R5 half-byte reads
    for (int rs = 0; rs < 2; rs++)
      for (int v = 0; v < 256; v++) begin
        rd_data = v[7:0]; busy = v[0];
        exp_b = rs ? v[7:0] : {v[0], v[6:0]};
        bus_cycle(1, rs[0], 8'h00, s, o);
        bus_cycle(1, rs[0], 8'h00, s2, o2);
        chk(o && o2 && s == {exp_b[7:4], 4'hF} && s2 == {exp_b[3:0], 4'hF},
            "R5", {s, s2}, {exp_b[7:4], 4'hF, exp_b[3:0], 4'hF});
      end

    // R6 snapshot across halves of a status read
    rd_data = 8'h5A; busy = 1;
    bus_cycle(1, 0, 8'h00, s, o);
    rd_data = 8'hC3; busy = 0;
    bus_cycle(1, 0, 8'h00, s2, o2);
    chk(s == 8'hDF && s2 == 8'hAF, "R6", {s, s2}, 16'hDFAF);

    // R9 reload of same mode keeps phase
    n0 = got_n;
    bus_cycle(0, 1, 8'h30, s, o);
    set_mode(1);
    bus_cycle(0, 1, 8'h70, s, o);
    chk(got_n == n0 + 1 && got_d == 8'h37, "R9", got_d, 8'h37);

    // R7 mode change discards pending half
    n0 = got_n;
    bus_cycle(0, 0, 8'h90, s, o);
    set_mode(0);
    set_mode(1);
    bus_cycle(0, 0, 8'h40, s, o);
    chk(got_n == n0, "R7", got_n, n0);
    bus_cycle(0, 0, 8'h20, s, o);
    chk(got_n == n0 + 1 && got_d == 8'h42, "R7", got_d, 8'h42);
    n0 = got_n;
    bus_cycle(0, 0, 8'hB0, s, o);
    set_mode(0);
    wr8(1, 8'h5C);
    chk(got_n == n0 + 1, "R7", got_n, n0 + 1);

    // R3 back-pressure hold and overwrite
    set_ready(0);
    bus_cycle(0, 1, 8'h66, s, o);
    chk(wr_valid && wr_data == 8'h66 && wr_rs, "R3", {wr_valid, wr_rs, wr_data}, {2'b11, 8'h66});
    cyc(10);
    chk(wr_valid && wr_data == 8'h66 && wr_rs, "R3", {wr_valid, wr_rs, wr_data}, {2'b11, 8'h66});
    bus_cycle(0, 0, 8'h22, s, o);
    chk(wr_valid && wr_data == 8'h22 && !wr_rs, "R3", {wr_valid, wr_rs, wr_data}, {2'b10, 8'h22});
    set_ready(1);
    cyc(2);
    chk(wr_valid == 0, "R3", wr_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule